// File: doc/BRIEF.md
# Dual-Edge Fractional Clock Divider

This block derives a slow, low-jitter oversample clock for audio converters from a fast reference clock, nominally 480 MHz. A 16-bit divide word sets the output rate as a fraction of the reference. The output can reach the standard audio sample rates at oversample bases of 512 or 384 and at their sub-multiples.

Each reference period holds two placement slots. The rising-edge slot comes first and the falling-edge slot second. The divide word is added to a phase accumulator once per slot. When an addition wraps, the output transition is placed on that slot's reference edge. This gives half-period placement resolution, about 1.04 ns at 480 MHz, so the periodic placement error stays well under the 2 ns correlated-jitter budget.

Each clock domain toggles only its own flop, and the output is the XOR of the two flops. When the enable is dropped, the output is parked low at a rising edge without a glitch.

Top module: `fracdiv_top`

## Requirements
- R1: While `rstN` is low, `divClk` is 0 and the phase accumulator is 0.
- R2: Let the phase start at zero when the block is enabled and grow by `divWord` in every slot, with the rising slot counted before the falling slot. After each slot, `divClk` equals bit 16 of that running sum. The output therefore toggles in exactly the slots whose 16-bit addition carries.
- R3: A transition belonging to the rising slot appears at the rising reference edge. A transition belonging to the falling slot appears at the following falling reference edge.
- R4: Starting from zero phase, 2N slots at a constant word D produce exactly floor(2N·D/65536) output transitions. The output frequency is therefore f_ref·D/2^16, with no cumulative drift.
- R5: While `divWord` is 0 and the block is enabled, `divClk` does not change.
- R6: `divWord` is sampled at each rising reference edge and is used for both slots of the period that begins at that edge. A new value takes effect at the next rising edge.
- R7: If `enable` is low at a rising edge, `divClk` is low from that edge on and the accumulator is cleared. When `enable` returns high, operation restarts from zero phase with the output low.
- R8: `divClk` changes only at reference edges, at most once per half period. No output level lasts less than half a reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control, sampled at rising reference edges |
| divWord | input | 16 | Fractional divide word, phase step per slot |
| divClk | output | 1 | Divided oversample clock |

## Verification
The hardest case to reach is parking. The output must drop low at a rising edge while the falling-edge flop holds a 1, with both toggle flops high. Only then does the output stay low only because the rising flop copies the falling flop instead of clearing. The stimulus runs random divide words for random lengths, which leaves both flops in arbitrary states. It then drops `enable` at random segment boundaries and checks the level in every half period. A long run at one fixed word checks the exact transition count against the closed-form rate.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

  // Number of placement slots per reference period (rising, then falling).
  localparam int SLOT_CNT  = 2;
  localparam int SLOT_RISE = 0;
  localparam int SLOT_FALL = 1;

  // Strobes from control to the accumulator datapath.
  typedef struct packed {
    logic clear;  // zero the phase accumulator
    logic step;   // advance the phase by one period (all slots)
  } accCmd_t;

  // Strobes from control to the dual-edge output stage.
  typedef struct packed {
    logic riseFlip; // toggle the rising-edge flop at this edge
    logic fallArm;  // toggle the falling-edge flop at the next falling edge
    logic park;     // force the output low and hold it
  } edgeCmd_t;

endpackage

// File: rtl/fracdiv_phase_dp.sv
module fracdiv_phase_dp
  import fracdiv_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                refClk,
  input  logic                rstN,
  input  accCmd_t             accCmd,
  input  logic [ACC_W-1:0]    divWord,
  output logic [SLOT_CNT-1:0] slotCarry,
  output logic [ACC_W-1:0]    accQ
);

  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] slotBase [SLOT_CNT+1];
  logic [SUM_W-1:0] slotSum  [SLOT_CNT];

  assign slotBase[0] = accQ;

  // One adder per slot, chained: each slot's residue seeds the next slot.
  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    assign slotSum[s]     = {1'b0, slotBase[s]} + {1'b0, divWord};
    assign slotBase[s+1]  = slotSum[s][ACC_W-1:0];
    assign slotCarry[s]   = slotSum[s][ACC_W];
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (accCmd.clear) begin
      accQ <= '0;
    end else if (accCmd.step) begin
      accQ <= slotBase[SLOT_CNT];
    end
  end

endmodule

// File: rtl/fracdiv_ctrl.sv
module fracdiv_ctrl
  import fracdiv_pkg::*;
(
  input  logic                enable,
  input  logic [SLOT_CNT-1:0] slotCarry,
  output accCmd_t             accCmd,
  output edgeCmd_t            edgeCmd
);

  always_comb begin
    accCmd          = '0;
    edgeCmd         = '0;
    accCmd.clear    = !enable;
    accCmd.step     = enable;
    edgeCmd.park    = !enable;
    edgeCmd.riseFlip = enable && slotCarry[SLOT_RISE];
    edgeCmd.fallArm  = enable && slotCarry[SLOT_FALL];
  end

endmodule

// File: rtl/fracdiv_edge_out.sv
module fracdiv_edge_out
  import fracdiv_pkg::*;
(
  input  logic     refClk,
  input  logic     rstN,
  input  edgeCmd_t edgeCmd,
  output logic     riseTglQ,
  output logic     fallPendQ,
  output logic     fallTglQ
);

  // Rising-edge domain: own toggle flop and the pending falling-slot decision.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      riseTglQ  <= 1'b0;
      fallPendQ <= 1'b0;
    end else if (edgeCmd.park) begin
      // Match the falling flop so the XOR output is low and stays low.
      riseTglQ  <= fallTglQ;
      fallPendQ <= 1'b0;
    end else begin
      if (edgeCmd.riseFlip) begin
        riseTglQ <= ~riseTglQ;
      end
      fallPendQ <= edgeCmd.fallArm;
    end
  end

  // Falling-edge domain: applies the decision registered half a period earlier.
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) begin
      fallTglQ <= 1'b0;
    end else if (fallPendQ) begin
      fallTglQ <= ~fallTglQ;
    end
  end

endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
  import fracdiv_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [ACC_W-1:0] divWord,
  output logic             divClk
);

  accCmd_t             accCmd;
  edgeCmd_t            edgeCmd;
  logic [SLOT_CNT-1:0] slotCarry;
  logic [ACC_W-1:0]    accQ;
  logic                riseTglQ;
  logic                fallPendQ;
  logic                fallTglQ;

  fracdiv_phase_dp #(.ACC_W(ACC_W)) phase_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .accCmd    (accCmd),
    .divWord   (divWord),
    .slotCarry (slotCarry),
    .accQ      (accQ)
  );

  fracdiv_ctrl ctrl_i (
    .enable    (enable),
    .slotCarry (slotCarry),
    .accCmd    (accCmd),
    .edgeCmd   (edgeCmd)
  );

  fracdiv_edge_out edge_i (
    .refClk    (refClk),
    .rstN      (rstN),
    .edgeCmd   (edgeCmd),
    .riseTglQ  (riseTglQ),
    .fallPendQ (fallPendQ),
    .fallTglQ  (fallTglQ)
  );

  assign divClk = riseTglQ ^ fallTglQ;

endmodule

// File: rtl/fracdiv_checks.sv
module fracdiv_checks #(
  parameter int ACC_W = 16
) (
  input logic             refClk,
  input logic             rstN,
  input logic             enable,
  input logic [ACC_W-1:0] divWord,
  input logic [ACC_W-1:0] accQ,
  input logic             divClk,
  input logic             fallPendQ,
  input logic             fallTglQ
);

  // R7: a low enable at one rising edge leaves the output low at the next.
  p_park_low_r7: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(enable) |-> !divClk);

  // R7: the accumulator is cleared after a disabled edge.
  p_acc_clear_r7: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(enable) |-> accQ == '0);

  // R5: a zero divide word leaves the output unchanged over the period.
  p_zero_hold_r5: assert property (@(posedge refClk) disable iff (!rstN)
    $past(enable && divWord == '0) |-> $stable(divClk));

  // R3: an armed falling slot toggles the falling flop before the next rising edge.
  p_fall_apply_r3: assert property (@(posedge refClk) disable iff (!rstN)
    fallPendQ |-> fallTglQ != $past(fallTglQ));

  // R3: without an armed falling slot the falling flop holds.
  p_fall_hold_r3: assert property (@(posedge refClk) disable iff (!rstN)
    !fallPendQ |-> fallTglQ == $past(fallTglQ));

endmodule

bind fracdiv_top fracdiv_checks #(.ACC_W(ACC_W)) checks_i (
  .refClk    (refClk),
  .rstN      (rstN),
  .enable    (enable),
  .divWord   (divWord),
  .accQ      (accQ),
  .divClk    (divClk),
  .fallPendQ (fallPendQ),
  .fallTglQ  (fallTglQ)
);

// File: tb/fracdiv_top_tb_top.sv
module fracdiv_top_tb_top;

  logic        refClk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [15:0] divWord;
  logic        divClk;

  int     nRun = 0;
  int     nFail = 0;
  longint phase = 0;
  int     edgeCnt = 0;
  logic   lastLvl = 1'b0;
  bit     done = 1'b0;

  always #4 refClk = ~refClk;

  fracdiv_top dut_i (
    .refClk  (refClk),
    .rstN    (rstN),
    .enable  (enable),
    .divWord (divWord),
    .divClk  (divClk)
  );

  function automatic logic expLevel(longint ph);
    return ph[16];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One slot: sample twice inside the half period, compare with the model.
  task automatic slotCheck(string req);
    logic a;
    logic b;
    #1 a = divClk;
    #2 b = divClk;
    check(a === b, "R8", "level stable within half period", b, a);
    check(b === expLevel(phase), req, "output level", b, expLevel(phase));
    if (b !== lastLvl) edgeCnt++;
    lastLvl = b;
  endtask

  // One reference period; inputs were set before the rising edge.
  task automatic period(string req);
    bit          en;
    logic [15:0] dv;
    en = rstN && enable;
    dv = divWord;
    @(posedge refClk);
    if (en) phase += dv; else phase = 0;
    slotCheck(req);
    @(negedge refClk);
    if (en) phase += dv;
    slotCheck(req);
  endtask

  task automatic runFor(int n, string req);
    for (int i = 0; i < n; i++) period(req);
  endtask

  initial begin
    int seg;
    rstN    = 1'b0;
    enable  = 1'b0;
    divWord = 16'h0;
    void'($urandom(32'h5eed_0001));

    // R1: reset state
    runFor(3, "R1");

    // R5: zero divide word, enabled
    rstN = 1'b1; enable = 1'b1; divWord = 16'h0;
    runFor(10, "R5");

    // R3: half-rate word lands every transition on a falling edge
    divWord = 16'h8000;
    runFor(20, "R3");

    // R2/R8: maximum word, transitions in nearly every slot
    divWord = 16'hFFFF;
    runFor(50, "R2");

    // R7: park, then restart from zero phase
    enable = 1'b0;
    runFor(3, "R7");
    enable = 1'b1; divWord = 16'h3039;  // 12345

    // R4: long run, exact transition count
    edgeCnt = 0;
    runFor(3000, "R4");
    check(edgeCnt == (6000 * 12345) / 65536, "R4", "transition count",
          edgeCnt, (6000 * 12345) / 65536);

    // R6/R7/R2: random words, in-flight word changes and random parking
    for (int k = 0; k < 30; k++) begin
      seg = 20 + int'($urandom_range(0, 120));
      case ($urandom_range(0, 3))
        0:       begin enable = 1'b0; runFor(2 + int'($urandom_range(0, 3)), "R7"); enable = 1'b1; end
        1:       divWord = 16'hFFFF - 16'($urandom_range(0, 15));
        default: divWord = 16'($urandom);
      endcase
      runFor(seg, "R6");
    end

    // R1: reset while running with a word that toggles often
    divWord = 16'hC001;
    runFor(7, "R2");
    rstN = 1'b0;
    runFor(2, "R1");
    rstN = 1'b1;
    runFor(20, "R2");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all requirements: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule